// File: doc/BRIEF.md
# SDRAM Burst Data-Phase Sequencer

This block sits beside an SDRAM command path. It times the data phase of each read and write. Every command the controller issues is shown to the sequencer in the same cycle. A mode-load command latches three settings: the burst length, the beat order and the read latency. The block then produces one beat per clock for each read or write. Each beat carries the column address that the beat touches.

Write beats come out directly as a write-data enable with its column. The first beat appears in the cycle of the write command itself. Read beats pass through a delay line as deep as the programmed read latency. They emerge as a read-capture enable with the column of the data being captured.

A burst-stop cancels the beats that have not yet been issued. A new read or write cuts the current burst short and starts its own burst in the same cycle. Read beats that were issued before the interruption still arrive at their proper latency.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset, both enables are low, and the mode is burst length 4, sequential order and read latency 3.
- R2: Command encoding on `cmd_i` is 0 no-op, 1 read, 2 write, 3 burst-stop and 4 mode-load; other codes act as no-op. A mode-load latches `mode_bl_i`, `mode_order_i` and `mode_cl_i`, and the new settings apply from the next command. `mode_bl_i` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 beats. `mode_order_i` 0 is sequential and 1 is interleaved. `mode_cl_i` 0 is latency 2 and 1 is latency 3.
- R3: A write asserts `wr_en_o` in the cycle of the command, with `wr_col_o` equal to `col_i`. It keeps `wr_en_o` asserted for the following BL-1 cycles, one beat per cycle.
- R4: A read issued in cycle t asserts `rd_cap_o` in cycles t+CL through t+CL+BL-1. In each of those cycles, `rd_col_o` gives the column of that beat.
- R5: In sequential order, beat k has its low log2(BL) column bits equal to (start low bits + k) mod BL.
- R6: In interleaved order, beat k has its low log2(BL) column bits equal to (start low bits) XOR k.
- R7: The column bits above the low log2(BL) bits equal those of the start column in every beat.
- R8: A burst-stop issues no beat in its own cycle or after it. Read beats issued before the stop still appear at their latency.
- R9: A read or write during an active burst ends the old burst and issues beat 0 of the new burst in the same cycle. Old read beats already issued still complete, so reads issued less than BL cycles apart give unbroken capture.
- R10: With burst length 1, each command produces exactly one beat.
- R11: A mode-load issues no beat and ends any active burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code of this cycle |
| col_i | input | COL_W | Start column of a read or write |
| mode_bl_i | input | 2 | Burst length code for a mode-load |
| mode_order_i | input | 1 | Beat order for a mode-load |
| mode_cl_i | input | 1 | Read latency select for a mode-load |
| wr_en_o | output | 1 | Write-data enable for this cycle |
| wr_col_o | output | COL_W | Column of the current write beat |
| rd_cap_o | output | 1 | Read-capture enable for this cycle |
| rd_col_o | output | COL_W | Column of the data being captured |

## Verification
The latency assertions on the read delay line take for granted that the read latency does not change while read beats are still in flight. A mode-load that changes the latency would otherwise move the tap under beats that are already travelling. The beat-bound assertion relies on the burst length changing only through a mode-load, which ends any burst. The stimulus issues every latency-changing mode-load only after at least four idle cycles. It issues mode-loads that interrupt a burst only while a write burst is active and the latency stays the same.

// File: rtl/sdr_bseq_pkg.sv
package sdr_bseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BSTOP = 3'd3,
        CMD_MODE  = 3'd4
    } seq_cmd_e;

endpackage

// File: rtl/sdr_mode_store.sv
module sdr_mode_store #(
    parameter int MAX_BL_LOG = 3,
    parameter int CL_MIN     = 2,
    parameter int CL_W       = 2,
    parameter int RST_BL_LOG = 2,
    parameter int RST_CL_SEL = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [$clog2(MAX_BL_LOG+1)-1:0] bl_code_i,
    input  logic                          order_i,
    input  logic                          cl_sel_i,
    output logic [$clog2(MAX_BL_LOG+1)-1:0] bl_log_o,
    output logic                          ilv_o,
    output logic [CL_W-1:0]               cl_o
);

    localparam int BLC_W = $clog2(MAX_BL_LOG + 1);

    typedef struct packed {
        logic [BLC_W-1:0] bl_log;
        logic             ilv;
        logic [CL_W-1:0]  cl;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (load_i) begin
            mode_d.bl_log = bl_code_i;
            mode_d.ilv    = order_i;
            mode_d.cl     = CL_W'(CL_MIN) + CL_W'(cl_sel_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.bl_log <= BLC_W'(RST_BL_LOG);
            mode_q.ilv    <= 1'b0;
            mode_q.cl     <= CL_W'(CL_MIN + RST_CL_SEL);
        end else begin
            mode_q <= mode_d;
        end
    end

    assign bl_log_o = mode_q.bl_log;
    assign ilv_o    = mode_q.ilv;
    assign cl_o     = mode_q.cl;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable({bl_log_o, ilv_o, cl_o})); // R2

endmodule

// File: rtl/sdr_beat_engine.sv
module sdr_beat_engine
    import sdr_bseq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [BLEN_W-1:0] bl_len_i,
    output logic              beat_vld_o,
    output logic              beat_rd_o,
    output logic [BLEN_W-1:0] beat_idx_o,
    output logic [COL_W-1:0]  beat_start_o
);

    typedef struct packed {
        logic              active;
        logic              rd;
        logic [BLEN_W-1:0] nxt;
        logic [COL_W-1:0]  start;
    } eng_t;

    eng_t s_d, s_q;
    logic is_xfer, is_halt;
    logic [BLEN_W-1:0] nxt_inc;

    always_comb begin
        is_xfer = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
        is_halt = (cmd_i == CMD_BSTOP) || (cmd_i == CMD_MODE);
        nxt_inc = s_q.nxt + BLEN_W'(1);

        s_d          = s_q;
        beat_vld_o   = 1'b0;
        beat_rd_o    = s_q.rd;
        beat_idx_o   = s_q.nxt;
        beat_start_o = s_q.start;

        if (is_xfer) begin
            beat_vld_o   = 1'b1;
            beat_rd_o    = (cmd_i == CMD_READ);
            beat_idx_o   = '0;
            beat_start_o = col_i;
            s_d.rd       = (cmd_i == CMD_READ);
            s_d.start    = col_i;
            s_d.nxt      = BLEN_W'(1);
            s_d.active   = (bl_len_i > BLEN_W'(1));
        end else if (is_halt) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            beat_vld_o = 1'b1;
            s_d.nxt    = nxt_inc;
            s_d.active = (nxt_inc < bl_len_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.nxt < bl_len_i)); // R3
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_BSTOP) |=> !s_q.active); // R8
    AST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_MODE) |=> !s_q.active); // R11

endmodule

// File: rtl/sdr_col_order.sv
module sdr_col_order #(
    parameter int COL_W  = 10,
    parameter int BLEN_W = 4,
    parameter int BLC_W  = 2
) (
    input  logic [COL_W-1:0]  start_i,
    input  logic [BLEN_W-1:0] idx_i,
    input  logic [BLC_W-1:0]  bl_log_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  col_o
);

    logic [COL_W-1:0] mask, idx_ext, low_seq, low_ilv;

    always_comb begin
        mask    = (COL_W'(1) << bl_log_i) - COL_W'(1);
        idx_ext = COL_W'(idx_i);
        low_seq = (start_i + idx_ext) & mask;
        low_ilv = (start_i ^ idx_ext) & mask;
        col_o   = (start_i & ~mask) | (ilv_i ? low_ilv : low_seq);
    end

endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe #(
    parameter int COL_W = 10,
    parameter int DEPTH = 3,
    parameter int CL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld_i,
    input  logic [COL_W-1:0] in_col_i,
    input  logic [CL_W-1:0]  cl_i,
    output logic             out_vld_o,
    output logic [COL_W-1:0] out_col_o
);

    localparam int TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic             vld;
        logic [COL_W-1:0] col;
    } stage_t;

    stage_t st_d [DEPTH];
    stage_t st_q [DEPTH];
    logic [TAP_W-1:0] tap;

    always_comb begin
        st_d[0].vld = in_vld_i;
        st_d[0].col = in_col_i;
        for (int k = 1; k < DEPTH; k++) begin
            st_d[k] = st_q[k-1];
        end
        tap       = TAP_W'(cl_i - CL_W'(1));
        out_vld_o = st_q[tap].vld;
        out_col_o = st_q[tap].col;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= '0;
            end else begin
                st_q[g] <= st_d[g];
            end
        end
    end

    AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_i == CL_W'(2)) && $past(in_vld_i, 2) |-> out_vld_o); // R4
    AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_i == CL_W'(3)) && $past(in_vld_i, 3) |-> out_vld_o); // R4
    AST_RD_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_i == CL_W'(2)) && out_vld_o |-> $past(in_vld_i, 2)); // R8

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_bseq_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int MAX_BL_LOG = 3,
    parameter int CL_MIN     = 2,
    parameter int CL_MAX     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [1:0]       mode_bl_i,
    input  logic             mode_order_i,
    input  logic             mode_cl_i,
    output logic             wr_en_o,
    output logic [COL_W-1:0] wr_col_o,
    output logic             rd_cap_o,
    output logic [COL_W-1:0] rd_col_o
);

    localparam int BLC_W  = $clog2(MAX_BL_LOG + 1);
    localparam int BLEN_W = MAX_BL_LOG + 1;
    localparam int CL_W   = $clog2(CL_MAX + 1);

    logic [BLC_W-1:0]  bl_log;
    logic              ilv;
    logic [CL_W-1:0]   cl;
    logic [BLEN_W-1:0] bl_len;
    logic              beat_vld, beat_rd;
    logic [BLEN_W-1:0] beat_idx;
    logic [COL_W-1:0]  beat_start, beat_col;

    sdr_mode_store #(
        .MAX_BL_LOG(MAX_BL_LOG), .CL_MIN(CL_MIN), .CL_W(CL_W),
        .RST_BL_LOG(2), .RST_CL_SEL(1)
    ) u_mode (
        .clk(clk), .rst_n(rst_n),
        .load_i(cmd_i == CMD_MODE),
        .bl_code_i(BLC_W'(mode_bl_i)),
        .order_i(mode_order_i), .cl_sel_i(mode_cl_i),
        .bl_log_o(bl_log), .ilv_o(ilv), .cl_o(cl)
    );

    assign bl_len = BLEN_W'(1) << bl_log;

    sdr_beat_engine #(.COL_W(COL_W), .BLEN_W(BLEN_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
        .bl_len_i(bl_len),
        .beat_vld_o(beat_vld), .beat_rd_o(beat_rd),
        .beat_idx_o(beat_idx), .beat_start_o(beat_start)
    );

    sdr_col_order #(.COL_W(COL_W), .BLEN_W(BLEN_W), .BLC_W(BLC_W)) u_col (
        .start_i(beat_start), .idx_i(beat_idx),
        .bl_log_i(bl_log), .ilv_i(ilv), .col_o(beat_col)
    );

    sdr_read_pipe #(.COL_W(COL_W), .DEPTH(CL_MAX), .CL_W(CL_W)) u_rdp (
        .clk(clk), .rst_n(rst_n),
        .in_vld_i(beat_vld && beat_rd), .in_col_i(beat_col),
        .cl_i(cl), .out_vld_o(rd_cap_o), .out_col_o(rd_col_o)
    );

    assign wr_en_o  = beat_vld && !beat_rd;
    assign wr_col_o = beat_col;

    AST_WR_ZERO_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WRITE) |-> (wr_en_o && (wr_col_o == col_i))); // R3
    AST_STOP_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_BSTOP) |-> !wr_en_o); // R8
    AST_RD_CUTS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_READ) |-> !wr_en_o); // R9

endmodule

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;

    localparam int COL_W = 10;
    localparam logic [2:0] C_NOP = 3'd0, C_RD = 3'd1, C_WR = 3'd2,
                           C_ST = 3'd3, C_MD = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cmd_i = C_NOP;
    logic [COL_W-1:0] col_i = '0;
    logic [1:0] mode_bl_i = 2'd0;
    logic mode_order_i = 1'b0;
    logic mode_cl_i = 1'b0;
    logic wr_en_o, rd_cap_o;
    logic [COL_W-1:0] wr_col_o, rd_col_o;

    always #4 clk = ~clk;

    sdr_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
        .mode_bl_i(mode_bl_i), .mode_order_i(mode_order_i), .mode_cl_i(mode_cl_i),
        .wr_en_o(wr_en_o), .wr_col_o(wr_col_o),
        .rd_cap_o(rd_cap_o), .rd_col_o(rd_col_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";

    int m_bl = 4, m_ilv = 0, m_cl = 3;
    int m_rem = 0, m_next = 0, m_st = 0, m_rd = 0;
    bit exp_v [16];
    int exp_c [16];

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int beat_col(int st, int k, int bl, int ilv);
        int mask = bl - 1;
        int low = ilv ? ((st & mask) ^ k) : (((st & mask) + k) & mask);
        return (st & ~mask & 32'h3FF) | low;
    endfunction

    task automatic step(logic [2:0] c, int a);
        int bv, idx, st, rd, col, slot;
        @(negedge clk);
        cmd_i = c;
        col_i = COL_W'(a);
        #3;
        bv = 0; idx = 0; st = 0; rd = 0;
        if (c == C_RD || c == C_WR) begin
            bv = 1; idx = 0; st = a; rd = (c == C_RD);
            m_rem = m_bl - 1; m_next = 1; m_st = a; m_rd = rd;
        end else if (c == C_ST || c == C_MD) begin
            m_rem = 0;
        end else if (m_rem > 0) begin
            bv = 1; idx = m_next; st = m_st; rd = m_rd;
            m_next++; m_rem--;
        end
        col = beat_col(st, idx, m_bl, m_ilv);
        chk("wr_en", int'(wr_en_o), (bv && !rd) ? 1 : 0);
        if (bv && !rd) chk("wr_col", int'(wr_col_o), col);
        slot = cyc % 16;
        chk("rd_cap", int'(rd_cap_o), int'(exp_v[slot]));
        if (exp_v[slot]) chk("rd_col", int'(rd_col_o), exp_c[slot]);
        exp_v[slot] = 1'b0;
        if (bv && rd) begin
            exp_v[(cyc + m_cl) % 16] = 1'b1;
            exp_c[(cyc + m_cl) % 16] = col;
        end
        if (c == C_MD) begin
            m_bl = 1 << mode_bl_i; m_ilv = mode_order_i; m_cl = 2 + mode_cl_i;
        end
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(C_NOP, 0);
    endtask

    task automatic set_mode(int blc, int ord, int cls);
        mode_bl_i = 2'(blc); mode_order_i = ord[0]; mode_cl_i = cls[0];
        step(C_MD, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin exp_v[i] = 1'b0; exp_c[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";  // reset state and default mode BL4 seq CL3
        idle(2);
        step(C_WR, 'h00D); idle(4);
        step(C_RD, 'h102); idle(7);

        cur_req = "R5";  // sequential wrap, upper bits kept (R7)
        set_mode(3, 0, 1);
        step(C_RD, 'h3FE); idle(12);
        step(C_WR, 'h1A5); idle(9);

        cur_req = "R6";  // interleaved with CL2 (R2, R4)
        set_mode(3, 1, 0); idle(4);
        step(C_WR, 'h035); idle(9);
        step(C_RD, 'h2F3); idle(11);
        set_mode(1, 1, 0);
        step(C_RD, 'h0C7); idle(5);

        cur_req = "R10";  // single-beat bursts
        set_mode(0, 0, 0);
        step(C_WR, 'h011); step(C_RD, 'h012); step(C_WR, 'h013); idle(4);

        cur_req = "R8";  // burst-stop on write and on read
        set_mode(3, 0, 1); idle(4);
        step(C_WR, 'h080); idle(2); step(C_ST, 0); idle(4);
        step(C_RD, 'h090); idle(1); step(C_ST, 0); idle(8);

        cur_req = "R9";  // interrupting bursts
        step(C_RD, 'h100); idle(2); step(C_RD, 'h204); idle(1);
        step(C_WR, 'h30A); idle(3); step(C_WR, 'h0F3); idle(12);
        step(C_RD, 'h011); step(C_RD, 'h022); step(C_RD, 'h033); idle(12);

        cur_req = "R11";  // mode-load ends a write burst
        step(C_WR, 'h155); idle(1); set_mode(2, 1, 1); idle(3);
        step(C_WR, 'h156); idle(5);

        cur_req = "R2";  // undefined command codes act as no-op
        step(C_RD, 'h041); step(3'd6, 0); step(3'd7, 0); idle(8);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog %s: actual timeout expected finish", cur_req);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule